// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Bridge

This block connects a synchronous on-chip requester to a 2M x 16 pseudo-static memory that has an asynchronous, SRAM-style pin interface. The requester presents single-word writes, single-word reads and page-burst reads with a valid/ready handshake. The controller turns each request into a sequence of memory pin states, and every phase lasts a whole number of clock cycles. Each returned word comes back as a one-cycle valid pulse.

Every phase length is a parameter given in nanoseconds. The block rounds each one up to clock cycles for the chosen clock period. A burst read keeps the upper address bits fixed and steps only the three lowest bits, so later words use the memory's faster in-page access time. Chip enable is never held low long enough to block the memory's hidden refresh. A burst that would run past that limit is cut short at a word boundary.

The data bus is split into a driven value, a per-byte drive enable and a returned value, so that a pad ring can build the bidirectional pins. The second chip-select pin is held high at all times, which keeps the memory out of its power-down state.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, chip enable, output enable, write enable and both byte strobes are high (inactive). The drive enables are 0, `req_ready` is 1, `rd_valid` is 0 and `mem_sel` is 1.
- R2: A read drives chip enable low, output enable low and write enable high. The word is returned on `rd_data` with a one-cycle `rd_valid` pulse exactly ACC cycles after the accepting edge (4 cycles at 50 MHz).
- R3: Bit 0 of `req_be` selects data bits 7..0 (`mem_lb_n` low) and bit 1 selects bits 15..8 (`mem_ub_n` low). A lane that is not enabled keeps its strobe high. During a write its drive enable stays 0, and during a read its `rd_data` byte is returned as zero.
- R4: `req_len` holds the word count minus one (0 means 1 word, 7 means 8 words). In a burst, address bits 20..3 stay constant. Bits 2..0 advance by one per word and wrap from 7 to 0. Each word after the first arrives PG cycles after the one before it (2 at 50 MHz).
- R5: A write holds chip enable and write enable low for WL cycles (3 at 50 MHz) while driving the write data. Output enable stays high for the whole write.
- R6: No drive enable is set while output enable is low. All drive enables are 0 in the cycle before output enable falls.
- R7: After every access, chip enable returns high for at least one cycle (GAP cycles). `req_ready` is low from the accepting edge until the gap ends, so the next request is accepted no earlier than 4 cycles after a write is accepted.
- R8: Chip enable never stays low for more than floor(MAX_CE_NS/CLK_NS)-1 consecutive cycles. A burst that would exceed this ends after the last word that fits. With MAX_CE_NS = 200, an 8-word burst returns 3 words and holds chip enable low for 8 cycles.
- R9: For a write, `req_len` is ignored: exactly one word is written and no `rd_valid` pulse is produced.
- R10: A burst produces exactly one `rd_valid` pulse per requested word, unless R8 cuts it short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address (start address for a burst) |
| req_len | input | 3 | Burst word count minus one (reads only) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane enables: bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle pulse per returned word |
| rd_data | output | 16 | Returned word, disabled lanes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_sel | output | 1 | Second chip select, held high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_addr | output | 21 | Memory address bus |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 2 | Per-byte drive enable for the data pads |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
A phase counter that is off by one shows up on the first access after reset. The `rd_valid` pulse either arrives a cycle early, and the memory model then returns stale data, or it arrives late at a cycle the bench checks exactly. A wrong burst-word counter or a wrong address step appears within one page interval as a missing or extra pulse, or as data read from the wrong word of the page. A drive enable left set, or a stuck chip enable, is caught in the same cycle by the monitors for overlap with output enable and for the chip-enable gap. An elapsed-time guard that counts badly changes how many words the shortened burst returns.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int AW = 21;
    localparam int DW = 16;
    localparam int NL = DW / 8;
    localparam int PB = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_GAP
    } st_e;

    typedef struct packed {
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic [NL-1:0] strb_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] dq;
        logic [NL-1:0] dq_oe;
    } pins_t;

    typedef struct packed {
        logic [PB-1:0] left;
        logic [NL-1:0] be;
    } job_t;

    function automatic int cyc_of(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/psram_ce_guard.sv
module psram_ce_guard #(
    parameter int CAP = 499,
    parameter int PG  = 2,
    parameter int EW  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic ce_n,
    output logic may_next
);
    localparam logic [EW-1:0] EMAX = '1;

    logic [EW-1:0] el;
    logic [EW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            el <= '0;
        end else if (start) begin
            el <= '0;
        end else if (active && el != EMAX) begin
            el <= el + 1'b1;
        end
    end

    // another page word ends PG cycles later; chip enable must then still be in bounds
    assign may_next = (int'(el) + PG + 1) <= CAP;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (ce_n) begin
            run <= '0;
        end else if (run != EMAX) begin
            run <= run + 1'b1;
        end
    end

    AST_CE_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(run) <= CAP); // R8

endmodule

// File: rtl/psram_lane_map.sv
module psram_lane_map
    import psram_pkg::*;
(
    input  logic [NL-1:0] be,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] kept
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign kept[g*8 +: 8] = be[g] ? raw[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int ACC_NS    = 70,
    parameter int OE_NS     = 25,
    parameter int PAGE_NS   = 30,
    parameter int WP_NS     = 50,
    parameter int CW_NS     = 60,
    parameter int DS_NS     = 30,
    parameter int WC_NS     = 70,
    parameter int MAX_CE_NS = 10000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [PB-1:0] req_len,
    input  logic [DW-1:0] req_wdata,
    input  logic [NL-1:0] req_be,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          mem_ce_n,
    output logic          mem_sel,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic [NL-1:0] mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int ACC_CYC = cyc_of(imax(ACC_NS, OE_NS), CLK_NS);
    localparam int PG_CYC  = cyc_of(PAGE_NS, CLK_NS);
    localparam int WL_CYC  = cyc_of(imax(WP_NS, imax(CW_NS, DS_NS)), CLK_NS);
    localparam int GAP_CYC = imax(1, cyc_of(WC_NS, CLK_NS) - WL_CYC);
    localparam int CE_CAP  = MAX_CE_NS / CLK_NS - 1;
    localparam int TMAX    = imax(imax(ACC_CYC, PG_CYC), imax(WL_CYC, GAP_CYC));
    localparam int TW      = $clog2(TMAX + 1) + 1;
    localparam int EW      = $clog2(CE_CAP + 2) + 1;

    st_e           st;
    pins_t         p;
    job_t          job;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          may_next;
    logic          accept;
    logic          more;
    logic [DW-1:0] kept;

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign more      = (job.left != '0) && may_next;

    // one down-counter times whichever phase is running
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            ST_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                tmr_val  = req_write ? TW'(WL_CYC) : TW'(ACC_CYC);
            end
            ST_RD: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_val  = more ? TW'(PG_CYC) : TW'(GAP_CYC);
            end
            ST_WR: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(GAP_CYC);
            end
            default: ;
        endcase
    end

    psram_phase_timer #(.TW(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .done (tmr_done)
    );

    psram_ce_guard #(.CAP(CE_CAP), .PG(PG_CYC), .EW(EW)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .active   (st == ST_RD),
        .ce_n     (p.ce_n),
        .may_next (may_next)
    );

    psram_lane_map u_lanes (
        .be   (job.be),
        .raw  (mem_dq_i),
        .kept (kept)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            p.ce_n   <= 1'b1;
            p.oe_n   <= 1'b1;
            p.we_n   <= 1'b1;
            p.strb_n <= '1;
            p.addr   <= '0;
            p.dq     <= '0;
            p.dq_oe  <= '0;
            job      <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    p.ce_n   <= 1'b0;
                    p.addr   <= req_addr;
                    p.strb_n <= ~req_be;
                    job.be   <= req_be;
                    if (req_write) begin
                        p.we_n   <= 1'b0;
                        p.dq     <= req_wdata;
                        p.dq_oe  <= req_be;
                        job.left <= '0;
                        st       <= ST_WR;
                    end else begin
                        p.oe_n   <= 1'b0;
                        job.left <= req_len;
                        st       <= ST_RD;
                    end
                end
                ST_RD: if (tmr_done) begin
                    rd_valid <= 1'b1;
                    rd_data  <= kept;
                    if (more) begin
                        job.left           <= job.left - 1'b1;
                        p.addr[PB-1:0]     <= p.addr[PB-1:0] + 1'b1;
                    end else begin
                        p.ce_n   <= 1'b1;
                        p.oe_n   <= 1'b1;
                        p.strb_n <= '1;
                        st       <= ST_GAP;
                    end
                end
                ST_WR: if (tmr_done) begin
                    p.ce_n   <= 1'b1;
                    p.we_n   <= 1'b1;
                    p.strb_n <= '1;
                    p.dq_oe  <= '0;
                    st       <= ST_GAP;
                end
                ST_GAP: if (tmr_done) begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_ce_n  = p.ce_n;
    assign mem_sel   = 1'b1;
    assign mem_oe_n  = p.oe_n;
    assign mem_we_n  = p.we_n;
    assign mem_lb_n  = p.strb_n[0];
    assign mem_ub_n  = p.strb_n[NL-1];
    assign mem_addr  = p.addr;
    assign mem_dq_o  = p.dq;
    assign mem_dq_oe = p.dq_oe;

    AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !p.oe_n |-> p.dq_oe == '0); // R6
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $fell(p.oe_n) |-> $past(p.dq_oe) == '0); // R6
    AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !p.we_n |-> p.oe_n); // R5
    AST_IDLE_CE_HIGH: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> p.ce_n); // R7
    AST_CE_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(p.ce_n) |=> p.ce_n); // R7
    AST_PAGE_HI: assert property (@(posedge clk) disable iff (rst)
        (!p.ce_n && !$past(p.ce_n)) |-> p.addr[AW-1:PB] == $past(p.addr[AW-1:PB])); // R4

endmodule

// File: tb/tb_psram_ctrl.sv
module tb_psram_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic        r_valid = 1'b0, r_write = 1'b0;
    logic [20:0] r_addr = '0;
    logic [2:0]  r_len = '0;
    logic [15:0] r_wdata = '0;
    logic [1:0]  r_be = '0;
    logic        r_ready, rd_valid;
    logic [15:0] rd_data;
    logic        ce_n, sel, oe_n, we_n, lb_n, ub_n;
    logic [20:0] maddr;
    logic [15:0] dq_o, dq_i;
    logic [1:0]  dq_oe;

    psram_ctrl dut (
        .clk(clk), .rst(rst),
        .req_valid(r_valid), .req_ready(r_ready), .req_write(r_write),
        .req_addr(r_addr), .req_len(r_len), .req_wdata(r_wdata), .req_be(r_be),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce_n(ce_n), .mem_sel(sel), .mem_oe_n(oe_n), .mem_we_n(we_n),
        .mem_lb_n(lb_n), .mem_ub_n(ub_n), .mem_addr(maddr),
        .mem_dq_o(dq_o), .mem_dq_oe(dq_oe), .mem_dq_i(dq_i)
    );

    logic        c_valid = 1'b0;
    logic        c_ready, c_rdv, c_ce_n, c_sel, c_oe_n, c_we_n, c_lb_n, c_ub_n;
    logic [15:0] c_rdata, c_dq_o;
    logic [20:0] c_addr;
    logic [1:0]  c_dq_oe;

    psram_ctrl #(.MAX_CE_NS(200)) dut_cap (
        .clk(clk), .rst(rst),
        .req_valid(c_valid), .req_ready(c_ready), .req_write(1'b0),
        .req_addr(21'h000100), .req_len(3'd7), .req_wdata(16'h0000), .req_be(2'b11),
        .rd_valid(c_rdv), .rd_data(c_rdata),
        .mem_ce_n(c_ce_n), .mem_sel(c_sel), .mem_oe_n(c_oe_n), .mem_we_n(c_we_n),
        .mem_lb_n(c_lb_n), .mem_ub_n(c_ub_n), .mem_addr(c_addr),
        .mem_dq_o(c_dq_o), .mem_dq_oe(c_dq_oe), .mem_dq_i(16'h0000)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // memory model: contents, access-time window, write commit
    logic [15:0] mm [256];
    logic [15:0] em [256];
    logic [15:0] dq_model = 16'hBAD0;
    assign dq_i = dq_model;

    bit          prev_rd = 0, full = 0, prev_oe = 1, prev_ce = 1, gap_pend = 0;
    logic [1:0]  prev_dq_oe = '0;
    logic [20:0] prev_addr = '0;
    int          age = 0, wl = 0;
    logic [15:0] wd;
    logic [1:0]  wmask;

    always @(negedge clk) begin
        bit rd, ok;
        logic [15:0] w;
        if (!rst) begin
            rd = !ce_n && !oe_n && we_n;
            if (!rd) age = 0;
            else if (!prev_rd || maddr[20:3] != prev_addr[20:3]) begin full = 1; age = 0; end
            else if (maddr != prev_addr) begin full = 0; age = 0; end
            else age++;
            ok = rd && (full ? age >= 3 : age >= 1);
            w = mm[maddr[7:0]];
            dq_model = ok ? {ub_n ? 8'hA5 : w[15:8], lb_n ? 8'hA5 : w[7:0]} : 16'hBAD0;
            if (!ce_n && !we_n) begin
                wl++;
                wd = dq_o;
                wmask = dq_oe & ~{ub_n, lb_n};
            end else if (wl > 0) begin
                chk(wl >= 3, "R5", "write pulse too short", wl, 3);
                if (wmask[0]) mm[prev_addr[7:0]][7:0]  = wd[7:0];
                if (wmask[1]) mm[prev_addr[7:0]][15:8] = wd[15:8];
                wl = 0;
            end
            if (!oe_n) chk(dq_oe == 2'b00, "R6", "drive while output enabled", dq_oe, 0);
            if (!oe_n && prev_oe) chk(prev_dq_oe == 2'b00, "R6", "no release before read", prev_dq_oe, 0);
            if (gap_pend) begin
                chk(ce_n, "R7", "chip enable gap", ce_n, 1);
                gap_pend = 0;
            end
            if (ce_n && !prev_ce) gap_pend = 1;
            prev_rd = rd; prev_addr = maddr; prev_oe = oe_n; prev_ce = ce_n; prev_dq_oe = dq_oe;
        end
    end

    task automatic send(input bit w, input [20:0] a, input [2:0] l, input [15:0] d, input [1:0] b);
        @(negedge clk);
        r_valid = 1; r_write = w; r_addr = a; r_len = l; r_wdata = d; r_be = b;
        while (!r_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        r_valid = 0;
    endtask

    task automatic do_write(input [20:0] a, input [15:0] d, input [1:0] b, input [2:0] l);
        int n = 0;
        bit oe_bad = 0, rdv = 0;
        send(1, a, l, d, b);
        for (int k = 0; k < 10; k++) begin
            if (!we_n) begin
                n++;
                if (n == 1) begin
                    chk(dq_oe == b, "R3", "write lane drive", dq_oe, b);
                    chk({ub_n, lb_n} == ~b, "R3", "write strobes", {ub_n, lb_n}, ~b);
                    chk(dq_o == d && !ce_n, "R5", "write data", dq_o, d);
                end
            end
            if (!oe_n) oe_bad = 1;
            if (rd_valid) rdv = 1;
            @(negedge clk);
        end
        chk(n == 3, "R5", "write enable low cycles", n, 3);
        chk(!oe_bad, "R5", "output enable during write", oe_bad, 0);
        chk(!rdv, "R9", "read pulse from write", rdv, 0);
        if (b[0]) em[a[7:0]][7:0]  = d[7:0];
        if (b[1]) em[a[7:0]][15:8] = d[15:8];
    endtask

    task automatic do_read(input [20:0] a, input int nw, input [1:0] b);
        int n = 0;
        logic [20:0] wa;
        logic [15:0] e;
        send(0, a, 3'(nw - 1), 16'h0, b);
        chk(!ce_n && !oe_n && we_n && {ub_n, lb_n} == ~b, "R2", "read pin state",
            {ce_n, oe_n, we_n, ub_n, lb_n}, {3'b001, ~b});
        for (int k = 0; k < 40; k++) begin
            if (k == 1) chk(!r_ready, "R7", "ready low while busy", r_ready, 0);
            if (rd_valid) begin
                wa = {a[20:3], 3'(a[2:0] + 3'(n))};
                e = em[wa[7:0]] & {{8{b[1]}}, {8{b[0]}}};
                chk(k == 4 + 2 * n, n == 0 ? "R2" : "R4", "word arrival cycle", k, 4 + 2 * n);
                chk(rd_data == e, b == 2'b11 ? "R4" : "R3", "read data", rd_data, e);
                n++;
            end
            @(negedge clk);
        end
        chk(n == nw, "R10", "word count", n, nw);
        chk(ce_n, "R7", "chip enable released", ce_n, 1);
    endtask

    task automatic t_reset();
        chk(ce_n && oe_n && we_n && lb_n && ub_n, "R1", "strobes idle",
            {ce_n, oe_n, we_n, lb_n, ub_n}, 5'h1F);
        chk(dq_oe == 0 && r_ready && !rd_valid && sel, "R1", "idle handshake",
            {dq_oe, r_ready, rd_valid, sel}, 5'b00101);
    endtask

    task automatic t_back_to_back();
        int k = 0;
        send(1, 21'h000033, 3'd0, 16'hC0DE, 2'b11);
        em[8'h33] = 16'hC0DE;
        while (!r_ready && k < 20) begin @(negedge clk); k++; end
        chk(k == 4, "R7", "write-to-next-accept cycles", k, 4);
        do_read(21'h000033, 1, 2'b11);
    endtask

    task automatic t_cap();
        int n = 0, run = 0, mx = 0;
        @(negedge clk);
        c_valid = 1;
        @(posedge clk);
        @(negedge clk);
        c_valid = 0;
        for (int k = 0; k < 40; k++) begin
            if (c_rdv) n++;
            if (!c_ce_n) begin run++; if (run > mx) mx = run; end else run = 0;
            @(negedge clk);
        end
        chk(n == 3, "R8", "truncated burst words", n, 3);
        chk(mx == 8, "R8", "chip enable low run", mx, 8);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mm[i] = 16'h4000 ^ 16'(i * 16'h0123);
            em[i] = mm[i];
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        do_write(21'h000010, 16'h1234, 2'b11, 3'd0);
        do_read(21'h000010, 1, 2'b11);
        do_write(21'h000020, 16'h99AB, 2'b01, 3'd0);
        do_read(21'h000020, 1, 2'b11);
        do_read(21'h000020, 1, 2'b10);
        do_read(21'h0A0040, 8, 2'b11);
        do_read(21'h00005D, 4, 2'b11);
        do_write(21'h000071, 16'h5EED, 2'b11, 3'd7);
        do_read(21'h000070, 3, 2'b11);
        t_back_to_back();
        t_cap();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule